// File: doc/BRIEF.md
# Resistive Cell Forming Check Sequencer

This block decides whether groups of resistive memory cells have ever been formed. A cell that was never formed does not switch, so anything written to it is lost and every read returns the same value. A formed cell stores what it is given. A part that arrives with formed cells in a group that should be virgin may have been used or probed, so a formed result is a tamper flag. In an ordinary memory test, identical readbacks after writing opposite data would be a failure. Here they are the good case.

The block is started with a one-cycle pulse and walks through the cell groups in ascending order. For each group it runs four accesses on a simple write/read port. It writes a test word supplied on an input and sampled at start. It reads the group back. It writes the bitwise inverse of the test word and reads the group back again. If the two reads match, the group is reported unformed. If they differ, it is reported formed.

Every access waits for the memory's ready. If ready does not arrive within a bounded number of cycles, the run ends with an access error and no verdict. The end of a run is marked by a one-cycle done pulse. The per-group flags, an overall any-formed flag and a verdict-valid flag are held until the next start.

Top module: `ffc_form_check`

## Requirements
- R1: After reset the block is idle. Busy, done, verdict-valid, access error, both strobes, all group flags and any-formed are 0.
- R2: A start pulse in idle runs four accesses for each group g = 0 .. NUM_GROUPS-1, in ascending order, at address BASE_ADDR+g. The four accesses are: write P, read, write ~P, read.
- R3: A write or read strobe, together with its address and write data, stays asserted until a cycle in which ready is high. The write and read strobes are never high together.
- R4: When the two reads of a group are equal, the group's bit in `group_formed_o` is 0 (unformed).
- R5: When the two reads of a group differ in any bit, the group's bit in `group_formed_o` is 1 (formed, possible tamper).
- R6: While the verdict is valid, `any_formed_o` is 1 exactly when at least one group bit is 1.
- R7: A completed run raises `done_o` for exactly one cycle. After it, `verdict_valid_o` and the result flags hold their values until the next accepted start, which clears them.
- R8: If ready stays low for TIMEOUT_CYC consecutive cycles of one access, the run ends with `done_o`. In that case `acc_err_o` is 1, `verdict_valid_o` is 0, and the group flags and `any_formed_o` are 0.
- R9: A start pulse while busy is ignored. The running test and its result are unchanged, and only one done pulse occurs.
- R10: The test word P is the value of `pattern_i` in the cycle the start is accepted. Changing `pattern_i` later has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| pattern_i | input | DATA_W | Test word, sampled at start |
| mem_addr_o | output | ADDR_W | Address of the group being accessed |
| mem_wdata_o | output | DATA_W | Write data |
| mem_we_o | output | 1 | Write strobe, held until ready |
| mem_re_o | output | 1 | Read strobe, held until ready |
| mem_ready_i | input | 1 | Access complete; read data valid with it on reads |
| mem_rdata_i | input | DATA_W | Read data |
| busy_o | output | 1 | A test is running |
| done_o | output | 1 | One-cycle end-of-run pulse |
| verdict_valid_o | output | 1 | Result flags hold a valid verdict |
| group_formed_o | output | NUM_GROUPS | Per-group formed flag |
| any_formed_o | output | 1 | At least one group formed |
| acc_err_o | output | 1 | Run aborted on an access timeout |

## Verification
The assertions take for granted that the memory raises ready for a single cycle, and only while a strobe is high. They also assume read data is meaningful only in that cycle and that start is a single-cycle pulse. The bench's memory model keeps to this. It counts latency only while a strobe is high, drops ready in the cycle after raising it, and never raises ready for a stalled group. Start pulses are always driven one cycle wide on the falling edge. Because of this, the hold and wait-bound properties are only ever exercised by legal handshakes.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_A,
    ST_RD_A,
    ST_WR_B,
    ST_RD_B,
    ST_FIN
  } ffc_state_e;
endpackage

// File: rtl/ffc_timer.sv
module ffc_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ready_i,
  output logic hs_o,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] wait_q;

  assign hs_o      = active_i && ready_i;
  assign timeout_o = active_i && !ready_i && (wait_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (!active_i || ready_i || timeout_o) begin
      wait_q <= '0;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/ffc_seq.sv
module ffc_seq
  import ffc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 16,
  parameter int GW         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic              acc_hs_i,
  input  logic              acc_to_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              run_clear_o,
  output logic              cmp_fire_o,
  output logic              cmp_differ_o,
  output logic [GW-1:0]     grp_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [GW-1:0]     LAST = GW'(NUM_GROUPS - 1);

  function automatic logic [DATA_W-1:0] flip_word(input logic [DATA_W-1:0] w);
    return ~w;
  endfunction

  function automatic logic reads_differ(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b);
    return |(a ^ b);
  endfunction

  ffc_state_e        state_q;
  logic [GW-1:0]     grp_q;
  logic [DATA_W-1:0] pat_q;
  logic [DATA_W-1:0] rd_a_q;

  assign we_o         = (state_q == ST_WR_A) || (state_q == ST_WR_B);
  assign re_o         = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign wdata_o      = (state_q == ST_WR_B) ? flip_word(pat_q) : pat_q;
  assign addr_o       = BASE + ADDR_W'(grp_q);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign run_clear_o  = (state_q == ST_IDLE) && start_i;
  assign cmp_fire_o   = (state_q == ST_RD_B) && acc_hs_i;
  assign cmp_differ_o = reads_differ(rd_a_q, rdata_i);
  assign grp_o        = grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      pat_q   <= '0;
      rd_a_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pat_q   <= pattern_i;
            grp_q   <= '0;
            state_q <= ST_WR_A;
          end
        end
        ST_WR_A: begin
          if (acc_to_i)      state_q <= ST_FIN;
          else if (acc_hs_i) state_q <= ST_RD_A;
        end
        ST_RD_A: begin
          if (acc_to_i) begin
            state_q <= ST_FIN;
          end else if (acc_hs_i) begin
            rd_a_q  <= rdata_i;
            state_q <= ST_WR_B;
          end
        end
        ST_WR_B: begin
          if (acc_to_i)      state_q <= ST_FIN;
          else if (acc_hs_i) state_q <= ST_RD_B;
        end
        ST_RD_B: begin
          if (acc_to_i) begin
            state_q <= ST_FIN;
          end else if (acc_hs_i) begin
            if (grp_q == LAST) begin
              state_q <= ST_FIN;
            end else begin
              grp_q   <= grp_q + 1'b1;
              state_q <= ST_WR_A;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ffc_verdict.sv
module ffc_verdict #(
  parameter int NUM_GROUPS = 4,
  parameter int GW         = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  cmp_fire_i,
  input  logic                  cmp_differ_i,
  input  logic [GW-1:0]         grp_i,
  input  logic                  abort_i,
  input  logic                  finish_i,
  output logic [NUM_GROUPS-1:0] group_formed_o,
  output logic                  any_formed_o,
  output logic                  valid_o,
  output logic                  err_o
);
  logic [NUM_GROUPS-1:0] formed_q;
  logic                  any_q;
  logic                  valid_q;
  logic                  err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      formed_q <= '0;
      any_q    <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else if (clear_i) begin
      formed_q <= '0;
      any_q    <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (cmp_fire_i) begin
        formed_q[grp_i] <= cmp_differ_i;
        if (cmp_differ_i) any_q <= 1'b1;
      end
      if (abort_i) err_q <= 1'b1;
      if (finish_i && !err_q) valid_q <= 1'b1;
    end
  end

  assign group_formed_o = valid_q ? formed_q : '0;
  assign any_formed_o   = valid_q && any_q;
  assign valid_o        = valid_q;
  assign err_o          = err_q;
endmodule

// File: rtl/ffc_form_check.sv
module ffc_form_check #(
  parameter int NUM_GROUPS  = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 16,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [DATA_W-1:0]     pattern_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  input  logic                  mem_ready_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  verdict_valid_o,
  output logic [NUM_GROUPS-1:0] group_formed_o,
  output logic                  any_formed_o,
  output logic                  acc_err_o
);
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic          acc_hs;
  logic          acc_to;
  logic          run_clear;
  logic          cmp_fire;
  logic          cmp_differ;
  logic [GW-1:0] cur_grp;

  ffc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (mem_we_o || mem_re_o),
    .ready_i  (mem_ready_i),
    .hs_o     (acc_hs),
    .timeout_o(acc_to)
  );

  ffc_seq #(
    .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .GW(GW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pattern_i   (pattern_i),
    .acc_hs_i    (acc_hs),
    .acc_to_i    (acc_to),
    .rdata_i     (mem_rdata_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .we_o        (mem_we_o),
    .re_o        (mem_re_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .run_clear_o (run_clear),
    .cmp_fire_o  (cmp_fire),
    .cmp_differ_o(cmp_differ),
    .grp_o       (cur_grp)
  );

  ffc_verdict #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_verdict (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (run_clear),
    .cmp_fire_i    (cmp_fire),
    .cmp_differ_i  (cmp_differ),
    .grp_i         (cur_grp),
    .abort_i       (acc_to),
    .finish_i      (done_o),
    .group_formed_o(group_formed_o),
    .any_formed_o  (any_formed_o),
    .valid_o       (verdict_valid_o),
    .err_o         (acc_err_o)
  );
endmodule

// File: rtl/ffc_form_check_chk.sv
module ffc_form_check_chk #(
  parameter int NUM_GROUPS  = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [DATA_W-1:0]     mem_wdata_o,
  input logic                  mem_we_o,
  input logic                  mem_re_o,
  input logic                  mem_ready_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  verdict_valid_o,
  input logic [NUM_GROUPS-1:0] group_formed_o,
  input logic                  any_formed_o,
  input logic                  acc_err_o
);
  logic [15:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt <= '0;
    else if ((mem_we_o || mem_re_o) && !mem_ready_i) stall_cnt <= stall_cnt + 1'b1;
    else stall_cnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !mem_ready_i && !(stall_cnt == 16'(TIMEOUT_CYC - 1)))
      |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && !mem_ready_i && !(stall_cnt == 16'(TIMEOUT_CYC - 1)))
      |=> (mem_re_o && $stable(mem_addr_o))); // R3
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid_o |-> (any_formed_o == (|group_formed_o))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_ERR_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> (!verdict_valid_o && group_formed_o == '0 && !any_formed_o)); // R8
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= 16'(TIMEOUT_CYC)); // R8
endmodule

bind ffc_form_check ffc_form_check_chk #(
  .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_we_o       (mem_we_o),
  .mem_re_o       (mem_re_o),
  .mem_ready_i    (mem_ready_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .verdict_valid_o(verdict_valid_o),
  .group_formed_o (group_formed_o),
  .any_formed_o   (any_formed_o),
  .acc_err_o      (acc_err_o)
);

// File: tb/ffc_form_check_tb.sv
module ffc_form_check_tb;
  localparam int NG   = 4;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int BASE = 16;
  localparam int TO   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] pattern_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_we_o, mem_re_o;
  logic          mem_ready_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o, verdict_valid_o, any_formed_o, acc_err_o;
  logic [NG-1:0] group_formed_o;

  int checks = 0;
  int fails = 0;

  // memory model configuration: 0 formed, 1 unformed (stuck), 2 only bit 0 writable, 3 never ready
  int            mode [NG];
  int            lat  [NG];
  logic [DW-1:0] stuck[NG];
  logic [DW-1:0] store[NG];
  int            wcnt;
  logic [DW-1:0] cur_pat;
  int            exp_step, exp_grp, seq_err, acc_cnt, done_cnt;

  always #5 clk = ~clk;

  ffc_form_check #(
    .NUM_GROUPS(NG), .DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE), .TIMEOUT_CYC(TO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pattern_i(pattern_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .verdict_valid_o(verdict_valid_o),
    .group_formed_o(group_formed_o), .any_formed_o(any_formed_o), .acc_err_o(acc_err_o)
  );

  always @(posedge clk) begin
    int g;
    if (!rst_n) begin
      mem_ready_i <= 1'b0;
      wcnt = 0;
    end else if (mem_ready_i) begin
      mem_ready_i <= 1'b0;
      wcnt = 0;
    end else if (mem_we_o || mem_re_o) begin
      g = int'(mem_addr_o) - BASE;
      if (g < 0 || g >= NG) begin
        seq_err++;
      end else if (mode[g] != 3) begin
        if (wcnt >= lat[g]) begin
          mem_ready_i <= 1'b1;
          acc_cnt++;
          // expected order: write P, read, write ~P, read, groups ascending (R2, R10)
          if (g != exp_grp) seq_err++;
          if (mem_we_o != (exp_step == 0 || exp_step == 2)) seq_err++;
          if (exp_step == 0 && mem_wdata_o != cur_pat) seq_err++;
          if (exp_step == 2 && mem_wdata_o != ~cur_pat) seq_err++;
          if (exp_step == 3) begin exp_step = 0; exp_grp++; end
          else exp_step++;
          if (mem_we_o) begin
            if (mode[g] == 0) store[g] = mem_wdata_o;
            else if (mode[g] == 2) store[g] = {stuck[g][DW-1:1], mem_wdata_o[0]};
          end else begin
            mem_rdata_i <= (mode[g] == 1) ? stuck[g] : store[g];
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input int m0, input int m1, input int m2, input int m3);
    mode[0] = m0; mode[1] = m1; mode[2] = m2; mode[3] = m3;
    for (int i = 0; i < NG; i++) begin
      lat[i]   = i % 3;
      stuck[i] = DW'(8'h5A + 8'(i * 17));
      store[i] = stuck[i];
    end
  endtask

  task automatic pulse_start(input logic [DW-1:0] pat);
    @(negedge clk);
    pattern_i = pat;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run(input logic [DW-1:0] pat, input bit extra_start);
    int n = 0;
    cur_pat = pat; exp_step = 0; exp_grp = 0; seq_err = 0; acc_cnt = 0; done_cnt = 0;
    pulse_start(pat);
    pattern_i = ~pat;  // later changes must not matter (R10)
    if (extra_start) begin
      repeat (4) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "strobes", {mem_we_o, mem_re_o}, 0);
    chk("R1", "valid/err/any", {verdict_valid_o, acc_err_o, any_formed_o}, 0);
    chk("R1", "group flags", group_formed_o, 0);
  endtask

  task automatic t_all_unformed;
    setup(1, 1, 1, 1);
    run(8'hA5, 1'b0);
    chk("R2", "sequence errors", seq_err, 0);
    chk("R2", "access count", acc_cnt, 4 * NG);
    chk("R4", "group flags", group_formed_o, 0);
    chk("R6", "any formed", any_formed_o, 0);
    chk("R7", "valid", verdict_valid_o, 1);
  endtask

  task automatic t_mixed;
    setup(0, 1, 2, 1);
    lat[1] = 3;
    run(8'h3C, 1'b0);
    chk("R3", "sequence with wait states", seq_err, 0);
    chk("R5", "group flags", group_formed_o, 4'b0101);
    chk("R6", "any formed", any_formed_o, 1);
    chk("R7", "done pulses", done_cnt, 1);
    repeat (20) @(negedge clk);
    chk("R7", "held flags", {verdict_valid_o, group_formed_o}, {1'b1, 4'b0101});
    chk("R7", "no further done", done_cnt, 1);
  endtask

  task automatic t_busy_start;
    setup(1, 0, 1, 1);
    run(8'h0F, 1'b1);
    chk("R9", "done pulses", done_cnt, 1);
    chk("R9", "access count", acc_cnt, 4 * NG);
    chk("R9", "group flags", group_formed_o, 4'b0010);
  endtask

  task automatic t_edge_patterns;
    setup(0, 0, 0, 0);
    run(8'h00, 1'b0);
    chk("R10", "sequence pattern 00", seq_err, 0);
    chk("R5", "all formed 00", group_formed_o, 4'b1111);
    setup(2, 2, 2, 2);
    run(8'hFF, 1'b0);
    chk("R10", "sequence pattern FF", seq_err, 0);
    chk("R5", "single writable bit FF", group_formed_o, 4'b1111);
    chk("R6", "any formed", any_formed_o, 1);
  endtask

  task automatic t_timeout;
    setup(0, 3, 0, 0);
    run(8'h81, 1'b0);
    chk("R8", "access error", acc_err_o, 1);
    chk("R8", "valid", verdict_valid_o, 0);
    chk("R8", "flags cleared", {group_formed_o, any_formed_o}, 0);
    chk("R8", "done pulses", done_cnt, 1);
    chk("R8", "strobes dropped", {mem_we_o, mem_re_o}, 0);
    setup(1, 0, 1, 1);
    run(8'h81, 1'b0);
    chk("R7", "start clears error", acc_err_o, 0);
    chk("R7", "fresh verdict", {verdict_valid_o, group_formed_o}, {1'b1, 4'b0010});
  endtask

  initial begin
    setup(1, 1, 1, 1);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_all_unformed;
    t_mixed;
    t_busy_start;
    t_edge_patterns;
    t_timeout;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule